// File: doc/BRIEF.md
# Hiccup Overload Protection Sequencer

This block decides when a regulator's power stage may drive its output. It watches a synchronized overload-detect flag and a pair of thermal comparator flags, and it produces the power-stage enable together with two diagnostic flags: an overload flag and an over-temperature flag. Software supplies two control bits. One is a global enable. The other selects between a static clamp mode and a dynamic (hiccup) mode.

In dynamic mode, an overload shuts the output off for a long off-window. The output is then allowed back on for an on-window one tenth as long. This repeats until an entire on-window passes with no overload, and only then does the sequencer return to idle. In static mode the output is never shut down, and the overload flag simply mirrors the detector. A thermal trip latches the over-temperature flag and blocks the output until the cool-down comparator reports that the junction has cooled. Both windows are counted in ticks of a prescaler, so the real durations come from parameters.

Top module: `hiccup_guard`

## Requirements
- R1: After reset the sequencer is idle, `olfFlag` and `otfFlag` are 0, and `outEn` equals `enBit`.
- R2: In dynamic mode (`staticMode`=0), an `ovld` high in an idle cycle drives `outEn` to 0 and `olfFlag` to 1 from the next cycle. This lasts exactly OFF_TICKS×TICK_DIV cycles.
- R3: After the off-window, `outEn` is 1 and `olfFlag` stays 1 for an on-window of (OFF_TICKS/10)×TICK_DIV cycles. If `ovld` stays low for the whole on-window, the sequencer returns to idle and `olfFlag` is 0 from the next cycle.
- R4: An `ovld` high in any cycle of the on-window, including its last cycle, starts a fresh full off-window in the next cycle.
- R5: `ovld` has no effect during the off-window. The length of the off-window does not change.
- R6: In static mode, `ovld` never lowers `outEn`, and `olfFlag` equals `ovld` in the same cycle.
- R7: Raising `staticMode` during a hiccup cycle gives static behaviour in that same cycle (`outEn`=1, `olfFlag`=`ovld`). The sequencer returns to idle.
- R8: With `enBit`=0, `outEn` and `olfFlag` are 0 in that same cycle and the sequencer returns to idle. `otfFlag` is not affected.
- R9: `thTrip` high sets `otfFlag` from the next cycle, and `outEn` is 0 while it is set. The flag holds until a cycle with `thClear` high and `thTrip` low, and it is 0 from the cycle after that one. When both inputs are high, the trip wins.
- R10: A thermal trip during a hiccup cycle returns the sequencer to idle, so `olfFlag` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ovld | input | 1 | Synchronized overload-detect flag |
| thTrip | input | 1 | Junction above the upper thermal threshold |
| thClear | input | 1 | Junction below the lower thermal threshold |
| enBit | input | 1 | Global enable from the control register |
| staticMode | input | 1 | 1 = static clamp mode, 0 = dynamic hiccup mode |
| outEn | output | 1 | Power-stage enable |
| olfFlag | output | 1 | Overload diagnostic flag |
| otfFlag | output | 1 | Over-temperature diagnostic flag |

## Verification
The assertions assume that all inputs are already synchronous to `clk`. They also assume that the two thermal comparators are hysteretic, so `thClear` only follows a trip. The timer-bound checks rely on the prescaler and the window counter being cleared whenever the sequencer changes phase. The stimulus changes inputs only just after a rising edge, and it holds each value for whole cycles. It also raises `thTrip` and `thClear` together once, to exercise the priority between them, and it never lets an overload pulse straddle a phase boundary except where a requirement targets that exact cycle.

// File: rtl/hiccup_guard_pkg.sv
package hiccup_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OFF  = 2'd1,
    PH_ON   = 2'd2
  } phase_t;

  // strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic clr;    // restart prescaler and window counter
    logic onWin;  // 1: compare against the short window, 0: the long one
  } timerCtl_t;

endpackage

// File: rtl/hiccup_guard_dp.sv
module hiccup_guard_dp
  import hiccup_guard_pkg::*;
#(
  parameter int TICK_DIV  = 4,
  parameter int OFF_TICKS = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCtl_t tctl,
  input  logic      thTrip,
  input  logic      thClear,
  output logic      winDone,
  output logic      otfQ
);

  localparam int ON_TICKS = (OFF_TICKS / 10 < 1) ? 1 : OFF_TICKS / 10;
  localparam int DIV_W    = $clog2(TICK_DIV + 1);
  localparam int CNT_W    = $clog2(OFF_TICKS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_TICKS - 1);
  localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_TICKS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] tickCnt;
  logic             tick;
  logic [CNT_W-1:0] winLast;

  assign tick    = (divCnt == DIV_LAST);
  assign winLast = tctl.onWin ? ON_LAST : OFF_LAST;
  assign winDone = tick && (tickCnt == winLast);

  always_ff @(posedge clk) begin
    if (!rstN || tctl.clr) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (tick) begin
      divCnt  <= '0;
      tickCnt <= tickCnt + 1'b1;
    end else begin
      divCnt  <= divCnt + 1'b1;
    end
  end

  // thermal latch: trip has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)        otfQ <= 1'b0;
    else if (thTrip)  otfQ <= 1'b1;
    else if (thClear) otfQ <= 1'b0;
  end

  assert_window_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= OFF_LAST);
  assert_trip_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    thTrip |=> otfQ);
  assert_trip_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (otfQ && !thClear) |=> otfQ);

endmodule

// File: rtl/hiccup_guard_ctrl.sv
module hiccup_guard_ctrl
  import hiccup_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ovld,
  input  logic      enBit,
  input  logic      staticMode,
  input  logic      thTrip,
  input  logic      otfQ,
  input  logic      winDone,
  output timerCtl_t tctl,
  output logic      outEn,
  output logic      olfFlag
);

  phase_t phase, phaseNxt;
  logic   hold;

  assign hold = !enBit || staticMode || thTrip || otfQ;

  always_comb begin
    phaseNxt = phase;
    if (hold) begin
      phaseNxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (ovld) phaseNxt = PH_OFF;
        PH_OFF:  if (winDone) phaseNxt = PH_ON;
        PH_ON: begin
          if (ovld)         phaseNxt = PH_OFF;
          else if (winDone) phaseNxt = PH_IDLE;
        end
        default: phaseNxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  assign tctl.clr   = (phase == PH_IDLE) || (phaseNxt != phase);
  assign tctl.onWin = (phase == PH_ON);

  assign outEn   = enBit && !otfQ && (staticMode || phase != PH_OFF);
  assign olfFlag = enBit && (staticMode ? ovld : (phase != PH_IDLE));

  assert_off_ignores_ovld_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OFF && !winDone && !hold) |=> phase == PH_OFF);
  assert_on_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ON && ovld && !hold) |=> phase == PH_OFF);
  assert_disable_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |=> phase == PH_IDLE);
  assert_static_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    staticMode |=> phase == PH_IDLE);
  assert_trip_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    thTrip |=> phase == PH_IDLE);

endmodule

// File: rtl/hiccup_guard.sv
module hiccup_guard
  import hiccup_guard_pkg::*;
#(
  parameter int TICK_DIV  = 4,
  parameter int OFF_TICKS = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic ovld,
  input  logic thTrip,
  input  logic thClear,
  input  logic enBit,
  input  logic staticMode,
  output logic outEn,
  output logic olfFlag,
  output logic otfFlag
);

  timerCtl_t tctl;
  logic      winDone;
  logic      otfQ;

  hiccup_guard_dp #(
    .TICK_DIV (TICK_DIV),
    .OFF_TICKS(OFF_TICKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tctl   (tctl),
    .thTrip (thTrip),
    .thClear(thClear),
    .winDone(winDone),
    .otfQ   (otfQ)
  );

  hiccup_guard_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ovld      (ovld),
    .enBit     (enBit),
    .staticMode(staticMode),
    .thTrip    (thTrip),
    .otfQ      (otfQ),
    .winDone   (winDone),
    .tctl      (tctl),
    .outEn     (outEn),
    .olfFlag   (olfFlag)
  );

  assign otfFlag = otfQ;

endmodule

// File: tb/hiccup_guard_bench.sv
module hiccup_guard_bench;

  localparam int TICK_DIV  = 4;
  localparam int OFF_TICKS = 50;
  localparam int OFF_CYC   = OFF_TICKS * TICK_DIV;
  localparam int ON_CYC    = (OFF_TICKS / 10) * TICK_DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ovld = 1'b0, thTrip = 1'b0, thClear = 1'b0, enBit = 1'b0, staticMode = 1'b0;
  logic outEn, olfFlag, otfFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [2:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  hiccup_guard #(.TICK_DIV(TICK_DIV), .OFF_TICKS(OFF_TICKS)) u_hiccup_guard (
    .clk(clk), .rstN(rstN), .ovld(ovld), .thTrip(thTrip), .thClear(thClear),
    .enBit(enBit), .staticMode(staticMode),
    .outEn(outEn), .olfFlag(olfFlag), .otfFlag(otfFlag)
  );

  // driver: one call per clock cycle, expected {outEn, olfFlag, otfFlag}
  task automatic cyc(input logic ov, input logic en, input logic st,
                     input logic tr, input logic tc, input logic [2:0] exp,
                     input string tag);
    @(posedge clk);
    #1;
    ovld = ov; enBit = en; staticMode = st; thTrip = tr; thClear = tc;
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic offWin(input logic ov, input string tag);
    for (int i = 0; i < OFF_CYC; i++) cyc(ov, 1, 0, 0, 0, 3'b010, tag);
  endtask

  task automatic onWin(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 3'b110, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, 0, 0, 3'b100, tag);
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (expQ.size() != 0) begin
      logic [2:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      testsRun++;
      if ({outEn, olfFlag, otfFlag} !== e) begin
        testsFailed++;
        $display("FAIL %s: {outEn,olf,otf} actual=%b expected=%b at %0t",
                 t, {outEn, olfFlag, otfFlag}, e, $time);
      end
    end
  end

  initial begin
    // R1: reset state
    cyc(0, 0, 0, 0, 0, 3'b000, "R1 in reset");
    cyc(0, 0, 0, 0, 0, 3'b000, "R1 in reset");
    @(posedge clk); #1 rstN = 1'b1;
    cyc(0, 1, 0, 0, 0, 3'b100, "R1 enabled idle");
    idle(2, "R1 idle");

    // R2 / R3: single overload pulse, clean on-window
    cyc(1, 1, 0, 0, 0, 3'b100, "R2 detect cycle");
    offWin(0, "R2 off-window");
    onWin(ON_CYC, "R3 on-window");
    idle(3, "R3 back to idle");

    // R5: overload held through the off-window
    cyc(1, 1, 0, 0, 0, 3'b100, "R5 detect cycle");
    offWin(1, "R5 off-window with overload held");
    onWin(ON_CYC, "R5 on-window");
    idle(2, "R5 idle");

    // R4: overload mid on-window, then on the last cycle
    cyc(1, 1, 0, 0, 0, 3'b100, "R4 detect cycle");
    offWin(0, "R4 first off");
    onWin(6, "R4 on before fault");
    cyc(1, 1, 0, 0, 0, 3'b110, "R4 fault in on-window");
    offWin(0, "R4 restarted off");
    onWin(ON_CYC - 1, "R4 on before last cycle");
    cyc(1, 1, 0, 0, 0, 3'b110, "R4 fault on last on cycle");
    offWin(0, "R4 off after last-cycle fault");
    onWin(ON_CYC, "R4 clean on-window");
    idle(2, "R4 idle");

    // R6: static mode
    cyc(1, 1, 1, 0, 0, 3'b110, "R6 static overload");
    cyc(1, 1, 1, 0, 0, 3'b110, "R6 static overload held");
    cyc(0, 1, 1, 0, 0, 3'b100, "R6 static clear");
    cyc(0, 1, 0, 0, 0, 3'b100, "R6 back to dynamic idle");

    // R7: static raised mid off-window
    cyc(1, 1, 0, 0, 0, 3'b100, "R7 detect cycle");
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, 3'b010, "R7 off part");
    cyc(1, 1, 1, 0, 0, 3'b110, "R7 static same cycle");
    cyc(0, 1, 1, 0, 0, 3'b100, "R7 static no overload");
    cyc(0, 1, 0, 0, 0, 3'b100, "R7 sequencer idle");
    idle(2, "R7 idle");

    // R8: enable dropped mid off-window
    cyc(1, 1, 0, 0, 0, 3'b100, "R8 detect cycle");
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, 3'b010, "R8 off part");
    cyc(1, 0, 0, 0, 0, 3'b000, "R8 disabled same cycle");
    cyc(0, 1, 0, 0, 0, 3'b100, "R8 sequencer idle");
    idle(2, "R8 idle");

    // R9: thermal latch and priority
    cyc(0, 1, 0, 1, 0, 3'b100, "R9 trip cycle");
    cyc(0, 1, 0, 0, 0, 3'b001, "R9 latched");
    cyc(0, 1, 0, 0, 0, 3'b001, "R9 held");
    cyc(0, 0, 0, 0, 0, 3'b001, "R8 otf kept when disabled");
    cyc(0, 1, 0, 1, 1, 3'b001, "R9 trip and clear");
    cyc(0, 1, 0, 0, 0, 3'b001, "R9 trip wins");
    cyc(0, 1, 0, 0, 1, 3'b001, "R9 clear cycle");
    cyc(0, 1, 0, 0, 0, 3'b100, "R9 cleared");

    // R10: trip during off-window
    cyc(1, 1, 0, 0, 0, 3'b100, "R10 detect cycle");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 3'b010, "R10 off part");
    cyc(0, 1, 0, 1, 0, 3'b010, "R10 trip cycle");
    cyc(0, 1, 0, 0, 0, 3'b001, "R10 idle with otf");
    cyc(0, 1, 0, 0, 1, 3'b001, "R10 clear cycle");
    idle(3, "R10 idle after cool-down");

    @(posedge clk);
    @(negedge clk);
    #1;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule